// File: doc/BRIEF.md
# 16-bit SEC-DED Memory Error Corrector

This block sits between a processor data bus and a memory that stores 22-bit words: 16 data bits plus 6 check bits. When data is written, the block computes the 6 check bits from the 16 data bits, and both are stored together. When data is read, the block takes the stored data and check bits and recomputes the check bits. From the difference it forms a 6-bit syndrome, flips a single failing data bit back to its correct value, and reports single or double errors on two flag outputs.

A 2-bit mode input selects the phase of operation:
- generate check bits from the live data input;
- drive the check bits of a data word held inside the block;
- capture a stored word and decode it;
- drive the corrected data, with the syndrome placed on the check lines.

The check bits are always driven: outward in the generate phases, and as the syndrome in the correct phase. A failure can therefore be located whether it is in a data bit or a check bit. A single error in a check bit is flagged but leaves the data untouched. Each bidirectional bus is modelled as an input port, an output port and an output enable.

Top module: `edac16_unit`

## Requirements
- R1: With mode 2'b00, chk_oe is 1 and data_oe is 0. chk_out equals the check word of data_in, with no clock edge in between. Each clock edge in this mode stores data_in as the held word.
- R2: Check bit j is the even parity (XOR) of the data bits i whose column has bit j set. The column of data bit i is the i-th value, counting from 0, in the ascending list of 6-bit values that have exactly three ones (7, 11, 13, 14, 19, ...). Check bit j alone has the column 1<<j.
- R3: With mode 2'b01, chk_oe is 1 and chk_out is the check word of the held word. Changes on data_in have no effect on it.
- R4: A clock edge in mode 2'b10 captures data_in and chk_in. It stores the syndrome chk_in XOR check-word(data_in) and the decode result.
- R5: With mode 2'b11, data_oe and chk_oe are both 1. data_out is the decoded data of the last capture and chk_out is its syndrome. With mode 2'b10, both enables are 0.
- R6: A zero syndrome raises neither flag, and the data is returned unchanged.
- R7: A syndrome that equals the column of a data bit sets single_err, clears double_err, and inverts that data bit on data_out.
- R8: A syndrome with exactly one bit set (an error in a check bit) sets single_err and leaves data_out equal to the captured data.
- R9: Any other nonzero syndrome sets double_err, clears single_err, and returns the captured data unmodified. This covers even weights, odd weight 3 that matches no column, and weight 5. The two flags are never high together.
- R10: A clock edge in mode 2'b00 or 2'b01 clears both flags. In mode 2'b11 the flags, the syndrome and the data are held.
- R11: While rst_n is low, the held word, the syndrome and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Phase select: 00 generate, 01 hold, 10 capture, 11 correct |
| data_in | input | 16 | Data bus inbound |
| chk_in | input | 6 | Check bus inbound (stored check bits) |
| data_out | output | 16 | Corrected data, valid in mode 11 |
| data_oe | output | 1 | Data bus drive enable |
| chk_out | output | 6 | Generated check word or syndrome |
| chk_oe | output | 1 | Check bus drive enable |
| single_err | output | 1 | Single error detected in last capture |
| double_err | output | 1 | Uncorrectable error detected in last capture |

## Verification
Two functions can meet in the same cycle: correction of the data field and reporting of the syndrome on the check lines. The bench provokes this by injecting every single-bit and every double-bit error into random codewords. Each faulty word is captured in mode 10 and then read in mode 11. For each injection, data_out, chk_out and both flags are judged together against the bit positions the bench flipped. A second overlap is that a capture refreshes the flags while the held word is also replaced. The bench judges this by reading the flags again after the next generate or hold edge, and by changing the inputs during a correct phase to show that nothing moves.

// File: rtl/edac16_pkg.sv
package edac16_pkg;
  localparam int DATA_W = 16;
  localparam int CHK_W  = 6;
  localparam int COL_WT = 3;

  typedef enum logic [1:0] {
    MD_GEN  = 2'b00,
    MD_HOLD = 2'b01,
    MD_CAPT = 2'b10,
    MD_FIX  = 2'b11
  } mode_e;

  // Column of data bit idx: idx-th value (ascending) with COL_WT ones.
  function automatic logic [CHK_W-1:0] col_of(input int idx);
    int n;
    logic [CHK_W-1:0] res;
    n   = 0;
    res = '0;
    for (int v = 0; v < (1 << CHK_W); v++) begin
      if ($countones(v[CHK_W-1:0]) == COL_WT) begin
        if (n == idx) res = v[CHK_W-1:0];
        n++;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/edac16_encoder.sv
module edac16_encoder
  import edac16_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic [DW-1:0] data,
  output logic [CW-1:0] chk
);
  logic [CW-1:0] term [DW];

  generate
    for (genvar i = 0; i < DW; i++) begin : g_term
      localparam logic [CW-1:0] COL = col_of(i);
      assign term[i] = data[i] ? COL : '0;
    end
  endgenerate

  always_comb begin
    chk = '0;
    for (int i = 0; i < DW; i++) chk = chk ^ term[i];
  end
endmodule

// File: rtl/edac16_decoder.sv
module edac16_decoder
  import edac16_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic [DW-1:0] data_raw,
  input  logic [CW-1:0] chk_raw,
  input  logic [CW-1:0] chk_calc,
  output logic [CW-1:0] syndrome,
  output logic [DW-1:0] data_fixed,
  output logic          sef,
  output logic          def
);
  logic [DW-1:0] hit;
  logic          chk_bit_err;

  assign syndrome = chk_raw ^ chk_calc;

  generate
    for (genvar i = 0; i < DW; i++) begin : g_hit
      localparam logic [CW-1:0] COL = col_of(i);
      assign hit[i] = (syndrome == COL);
    end
  endgenerate

  assign chk_bit_err = ($countones(syndrome) == 1);
  assign data_fixed  = data_raw ^ hit;
  assign sef         = (|hit) | chk_bit_err;
  assign def         = (syndrome != '0) & ~sef;

  always_comb begin
    if (def) assert (data_fixed == data_raw); // R9
    if (syndrome == '0) assert (!sef && !def); // R6
  end
endmodule

// File: rtl/edac16_unit.sv
module edac16_unit
  import edac16_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [DW-1:0] data_in,
  input  logic [CW-1:0] chk_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic [CW-1:0] chk_out,
  output logic          chk_oe,
  output logic          single_err,
  output logic          double_err
);
  mode_e md;
  assign md = mode_e'(mode);

  // state
  logic [DW-1:0] word_q, word_d;
  logic [CW-1:0] syn_q, syn_d;
  logic          sef_q, sef_d, def_q, def_d;
  logic          word_en, syn_en, flag_en;

  // datapath
  logic [DW-1:0] enc_src;
  logic [CW-1:0] enc_val;
  logic [CW-1:0] dec_syn;
  logic [DW-1:0] dec_data;
  logic          dec_sef, dec_def;

  assign enc_src = (md == MD_HOLD) ? word_q : data_in;

  edac16_encoder #(.DW(DW), .CW(CW)) u_enc (
    .data (enc_src),
    .chk  (enc_val)
  );

  edac16_decoder #(.DW(DW), .CW(CW)) u_dec (
    .data_raw   (data_in),
    .chk_raw    (chk_in),
    .chk_calc   (enc_val),
    .syndrome   (dec_syn),
    .data_fixed (dec_data),
    .sef        (dec_sef),
    .def        (dec_def)
  );

  // next state
  always_comb begin
    word_en = (md == MD_GEN) || (md == MD_CAPT);
    syn_en  = (md == MD_CAPT);
    flag_en = (md != MD_FIX);
    word_d  = (md == MD_CAPT) ? dec_data : data_in;
    syn_d   = dec_syn;
    sef_d   = (md == MD_CAPT) ? dec_sef : 1'b0;
    def_d   = (md == MD_CAPT) ? dec_def : 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      syn_q  <= '0;
      sef_q  <= 1'b0;
      def_q  <= 1'b0;
    end else begin
      if (word_en) word_q <= word_d;
      if (syn_en)  syn_q  <= syn_d;
      if (flag_en) begin
        sef_q <= sef_d;
        def_q <= def_d;
      end
    end
  end

  // outputs
  always_comb begin
    data_oe  = (md == MD_FIX);
    chk_oe   = (md != MD_CAPT);
    data_out = data_oe ? word_q : '0;
    unique case (md)
      MD_GEN, MD_HOLD: chk_out = enc_val;
      MD_FIX:          chk_out = syn_q;
      default:         chk_out = '0;
    endcase
  end

  assign single_err = sef_q;
  assign double_err = def_q;

  // assertions
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (md == MD_HOLD) |=> (md != MD_HOLD) || $stable(chk_out)); // R3
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] == 1'b0) |=> (!single_err && !double_err)); // R10
  AST_FIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (md == MD_FIX) |=> $stable({single_err, double_err, word_q, syn_q})); // R10
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(single_err && double_err)); // R9
  AST_SEF_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (md == MD_FIX && single_err) |-> ($countones(chk_out) % 2 == 1)); // R7
  AST_DEF_NOFIX: assert property (@(posedge clk) disable iff (!rst_n)
    (md == MD_CAPT && dec_def) |=> (word_q == $past(data_in))); // R9
endmodule

// File: tb/sim_edac16_unit.sv
module sim_edac16_unit;
  logic        clk;
  logic        rst_n;
  logic [1:0]  mode;
  logic [15:0] data_in;
  logic [5:0]  chk_in;
  logic [15:0] data_out;
  logic        data_oe;
  logic [5:0]  chk_out;
  logic        chk_oe;
  logic        single_err;
  logic        double_err;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  edac16_unit u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .data_in(data_in), .chk_in(chk_in),
    .data_out(data_out), .data_oe(data_oe), .chk_out(chk_out), .chk_oe(chk_oe),
    .single_err(single_err), .double_err(double_err)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // R2: column list computed from its definition
  function automatic logic [5:0] ref_col(input int idx);
    int n = 0;
    for (int v = 0; v < 64; v++) begin
      if ($countones(v[5:0]) == 3) begin
        if (n == idx) return v[5:0];
        n++;
      end
    end
    return 6'd0;
  endfunction

  function automatic logic [5:0] ref_enc(input logic [15:0] d);
    logic [5:0] p = '0;
    for (int j = 0; j < 6; j++)
      for (int i = 0; i < 16; i++)
        if (ref_col(i)[j]) p[j] = p[j] ^ d[i];
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // capture (mode 10) then read (mode 11)
  task automatic do_read(input logic [15:0] d, input logic [5:0] c,
                         input logic [15:0] exp_d, input logic [5:0] exp_s,
                         input bit exp_sef, input bit exp_def, input string req);
    @(negedge clk);
    mode = 2'b10; data_in = d; chk_in = c;
    #1;
    chk(!data_oe && !chk_oe, "R5 capture enables", {data_oe, chk_oe}, 0);
    @(negedge clk);
    mode = 2'b11; data_in = $urandom; chk_in = $urandom;
    #1;
    chk(data_oe && chk_oe, "R5 fix enables", {data_oe, chk_oe}, 3);
    chk(data_out == exp_d, {req, " data"}, data_out, exp_d);
    chk(chk_out == exp_s, {"R4 syndrome ", req}, chk_out, exp_s);
    chk(single_err == exp_sef && double_err == exp_def, {req, " flags"},
        {single_err, double_err}, {exp_sef, exp_def});
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] d, d2;
    logic [5:0]  c;
    void'($urandom(32'h5eed_0a11));
    rst_n = 0; mode = 2'b11; data_in = '0; chk_in = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(data_out == 0 && chk_out == 0 && !single_err && !double_err, "R11 reset",
        {data_out, chk_out, single_err, double_err}, 0);
    @(negedge clk); rst_n = 1;

    // R1 / R2 generate
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      mode = 2'b00;
      d = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : (k < 18) ? (16'h1 << (k - 2)) : 16'($urandom);
      data_in = d;
      #1;
      chk(chk_out == ref_enc(d) && chk_oe && !data_oe, "R1 R2 generate", chk_out, ref_enc(d));
    end

    // R3 hold
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); mode = 2'b00; d = $urandom; data_in = d;
      @(negedge clk); mode = 2'b01; d2 = ~d; data_in = d2;
      #1; chk(chk_out == ref_enc(d) && chk_oe, "R3 hold", chk_out, ref_enc(d));
      @(negedge clk); data_in = $urandom;
      #1; chk(chk_out == ref_enc(d), "R3 hold ignores input", chk_out, ref_enc(d));
    end

    // exhaustive injection over random codewords
    for (int w = 0; w < 6; w++) begin
      logic [21:0] cw, bad;
      d = (w == 0) ? 16'h0000 : 16'($urandom);
      c = ref_enc(d);
      cw = {c, d};
      do_read(d, c, d, 6'd0, 0, 0, "R6 clean");
      for (int a = 0; a < 22; a++) begin
        bad = cw ^ (22'd1 << a);
        if (a < 16)
          do_read(bad[15:0], bad[21:16], d, ref_col(a), 1, 0, "R7 data single");
        else
          do_read(bad[15:0], bad[21:16], bad[15:0], 6'd1 << (a - 16), 1, 0, "R8 check single");
      end
      for (int a = 0; a < 22; a++)
        for (int b = a + 1; b < 22; b++) begin
          logic [5:0] es;
          bad = cw ^ (22'd1 << a) ^ (22'd1 << b);
          es = bad[21:16] ^ ref_enc(bad[15:0]);
          do_read(bad[15:0], bad[21:16], bad[15:0], es, 0, 1, "R9 double");
        end
    end

    // R9 odd-weight syndromes matching no column (weight 3 unused, weight 5)
    d = $urandom;
    do_read(d, ref_enc(d) ^ 6'b110001, d, 6'b110001, 0, 1, "R9 unused col");
    do_read(d, ref_enc(d) ^ 6'b111110, d, 6'b111110, 0, 1, "R9 weight5");

    // R10 hold in fix, clear on generate / hold edge
    do_read(d, ref_enc(d) ^ 6'b000011, d, 6'b000011, 0, 1, "R9 pre-hold");
    @(negedge clk); data_in = ~d; chk_in = 6'h2a;
    #1; chk(double_err && data_out == d && chk_out == 6'b000011, "R10 fix hold",
            {double_err, data_out, chk_out}, {1'b1, d, 6'b000011});
    @(negedge clk); mode = 2'b00;
    @(negedge clk); #1;
    chk(!single_err && !double_err, "R10 clear gen", {single_err, double_err}, 0);
    do_read(d ^ 16'h1, ref_enc(d), d, ref_col(0), 1, 0, "R7 pre-clear");
    @(negedge clk); mode = 2'b01;
    @(negedge clk); #1;
    chk(!single_err && !double_err, "R10 clear hold", {single_err, double_err}, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule